// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard

This block decides, once per clock, whether a decoded single-precision floating-point operation may start. The coprocessor behind it has a multiplier and a second shared unit. That shared unit performs add, subtract, compare, both conversions, divide, square root, absolute value, move and negate. Loads and stores to the register file run on a separate transfer path. The block never computes a value. It only keeps timers: a repeat-rate timer for the multiplier, an occupancy timer for the shared unit, a pending-result countdown for every register, and a timeline of completion slots.

Each request is answered in the next cycle with exactly one of three outcomes. It is accepted, or it is stalled (the requester must present it again), or it is trapped. A trap happens when the request asks for double precision or carries a reserved operation code; the integer side can then emulate the operation. A trapped request changes no state, so exceptions stay precise. Every accepted operation later produces a one-cycle completion token, which names its operation code and destination register. When two completions would land in the same cycle, the earlier-issued one keeps its cycle and the later one moves back.

Top module: `fpsb_issue_ctl`

## Requirements
- R1: While rst is high, and in the first cycle after it is released with req_valid low, all outputs (issue_ok, issue_stall, issue_trap, cpl_valid) are low, even if req_valid is driven high during reset.
- R2: Operation codes and latencies L in cycles: 0 add 4, 1 subtract 4, 2 multiply 8, 3 divide 32, 4 square root 31, 5 compare 3, 6 float-to-fixed 4, 7 fixed-to-float 6, 8 absolute 1, 9 move 1, 10 negate 1, 11 load 2, 12 store 1. A request accepted at clock edge E raises issue_ok for the cycle after E. With no clash, cpl_valid pulses for one cycle starting at edge E+L.
- R3: Code 2 uses the multiplier. After a multiply is accepted at edge E, another multiply is stalled at edges E+1 to E+5 and may be accepted at E+6 (repeat rate MUL_RATE).
- R4: A multiply and a shared-unit operation may be accepted on consecutive edges, with both in flight at once.
- R5: Codes 0, 1 and 3 to 10 use the shared unit. It takes a new operation only when idle: after acceptance at E with latency L, further shared-unit requests stall until edge E+L. Loads and stores (11, 12) are not held by it.
- R6: Source A is read by codes 0 to 10 and 12, source B by codes 0 to 3 and 5, and the destination is written by all codes except 5 and 12. A request that touches a register whose result is pending is stalled until the edge at which that result's cpl_valid pulse begins, and accepted from that edge.
- R7: A request with req_dbl high, or with code 13, 14 or 15, raises issue_trap in the next cycle, is never accepted, never completes, and leaves every timer untouched. A trap takes precedence over any stall cause.
- R8: When an accepted operation's completion edge E+L is already taken, it takes the first free edge among E+L+1 up to E+L+SLACK. The earlier-issued operation therefore completes first. Its register stays pending until its own, later pulse. If no such edge is free, the request is stalled.
- R9: For each request exactly one of issue_ok, issue_stall, issue_trap is high in the following cycle. All three are low in a cycle that follows an edge where req_valid was low.
- R10: During a cpl_valid pulse, cpl_op carries the operation code, cpl_dst carries the request's req_dst, and cpl_wr is high exactly for operations that write a destination (every code except 5 and 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 4 | Operation code (R2) |
| req_dbl | input | 1 | Request asks for double precision |
| req_dst | input | $clog2(NREG) | Destination register |
| req_sa | input | $clog2(NREG) | Source register A |
| req_sb | input | $clog2(NREG) | Source register B |
| issue_ok | output | 1 | Previous request was accepted |
| issue_stall | output | 1 | Previous request was stalled |
| issue_trap | output | 1 | Previous request was trapped |
| cpl_valid | output | 1 | Completion token this cycle |
| cpl_op | output | 4 | Operation code of the completing operation |
| cpl_dst | output | $clog2(NREG) | Destination of the completing operation |
| cpl_wr | output | 1 | Completing operation writes its destination |

## Verification
The bench builds the block with its defaults: 32 registers, a multiply repeat rate of 6 and two slots of completion slack. With those values the 32-cycle divide fits the timeline, and a three-way pile-up of multiply, load and absolute value on one completion edge can be set up. That pile-up pushes a dependent multiply through two stall cycles. The same values allow the multiplier gap to be probed one edge before and exactly at its limit.

// File: rtl/fpsb_pkg.sv
`timescale 1ns/1ps
package fpsb_pkg;

  localparam int OPW     = 4;
  localparam int LATW    = 6;
  localparam int MAX_LAT = 32;

  localparam logic [OPW-1:0] OP_ADD   = 4'd0;
  localparam logic [OPW-1:0] OP_SUB   = 4'd1;
  localparam logic [OPW-1:0] OP_MUL   = 4'd2;
  localparam logic [OPW-1:0] OP_DIV   = 4'd3;
  localparam logic [OPW-1:0] OP_SQRT  = 4'd4;
  localparam logic [OPW-1:0] OP_CMP   = 4'd5;
  localparam logic [OPW-1:0] OP_TOFIX = 4'd6;
  localparam logic [OPW-1:0] OP_TOFLT = 4'd7;
  localparam logic [OPW-1:0] OP_ABS   = 4'd8;
  localparam logic [OPW-1:0] OP_MOV   = 4'd9;
  localparam logic [OPW-1:0] OP_NEG   = 4'd10;
  localparam logic [OPW-1:0] OP_LOAD  = 4'd11;
  localparam logic [OPW-1:0] OP_STORE = 4'd12;

  typedef enum logic [1:0] {
    U_MUL   = 2'd0,
    U_ARITH = 2'd1,
    U_XFER  = 2'd2
  } unit_e;

  typedef struct packed {
    logic            legal;
    unit_e           unit;
    logic [LATW-1:0] lat;
    logic            rd_a;
    logic            rd_b;
    logic            wr_d;
  } dec_t;

  // Static properties of each operation code: unit, latency, register use.
  function automatic dec_t op_decode(input logic [OPW-1:0] op);
    dec_t d;
    d.legal = 1'b1;
    d.unit  = U_ARITH;
    d.lat   = '0;
    d.rd_a  = 1'b1;
    d.rd_b  = 1'b0;
    d.wr_d  = 1'b1;
    case (op)
      OP_ADD, OP_SUB: begin d.lat = LATW'(4); d.rd_b = 1'b1; end
      OP_MUL:   begin d.unit = U_MUL; d.lat = LATW'(8); d.rd_b = 1'b1; end
      OP_DIV:   begin d.lat = LATW'(32); d.rd_b = 1'b1; end
      OP_SQRT:  d.lat = LATW'(31);
      OP_CMP:   begin d.lat = LATW'(3); d.rd_b = 1'b1; d.wr_d = 1'b0; end
      OP_TOFIX: d.lat = LATW'(4);
      OP_TOFLT: d.lat = LATW'(6);
      OP_ABS, OP_MOV, OP_NEG: d.lat = LATW'(1);
      OP_LOAD:  begin d.unit = U_XFER; d.lat = LATW'(2); d.rd_a = 1'b0; end
      OP_STORE: begin d.unit = U_XFER; d.lat = LATW'(1); d.wr_d = 1'b0; end
      default:  begin d.legal = 1'b0; d.rd_a = 1'b0; d.wr_d = 1'b0; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/fpsb_countdown.sv
`timescale 1ns/1ps
// Loadable down-counter; busy while non-zero.
module fpsb_countdown #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          busy
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/fpsb_reg_pend.sv
`timescale 1ns/1ps
// One pending-result countdown per register of the file.
module fpsb_reg_pend #(
  parameter int NREG = 32,
  parameter int AW   = 5,
  parameter int CW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [AW-1:0]   ld_idx,
  input  logic [CW-1:0]   ld_val,
  output logic [NREG-1:0] busy
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    fpsb_countdown #(.CW(CW)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .load (ld && (ld_idx == AW'(g))),
      .val  (ld_val),
      .busy (busy[g])
    );
  end

endmodule

// File: rtl/fpsb_timeline.sv
`timescale 1ns/1ps
// Completion timeline: slot k holds the token that completes k+1 edges from now.
module fpsb_timeline #(
  parameter int DEPTH = 35,
  parameter int SLACK = 2,
  parameter int AW    = 5,
  parameter int CW    = 6,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] want_lat,
  input  logic          put,
  input  logic [3:0]    put_op,
  input  logic [AW-1:0] put_dst,
  input  logic          put_wr,
  output logic          fit,
  output logic [CW-1:0] fit_at,
  output logic          out_v,
  output logic [3:0]    out_op,
  output logic [AW-1:0] out_dst,
  output logic          out_wr
);

  logic              v_q   [DEPTH];
  logic [3:0]        op_q  [DEPTH];
  logic [AW-1:0]     dst_q [DEPTH];
  logic              wr_q  [DEPTH];
  logic [(1<<CW)-1:0] occ;
  logic [IW-1:0]     ins;

  always_comb begin
    occ = '0;
    for (int k = 0; k < DEPTH; k++) occ[k] = v_q[k];
  end

  // Earliest free completion edge at or after the nominal latency.
  always_comb begin
    fit    = 1'b0;
    fit_at = want_lat;
    for (int e = SLACK; e >= 0; e--) begin
      if (!occ[want_lat + CW'(e)]) begin
        fit    = 1'b1;
        fit_at = want_lat + CW'(e);
      end
    end
  end

  assign ins = IW'(fit_at - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) v_q[k] <= 1'b0;
      out_v <= 1'b0;
    end else begin
      for (int k = 0; k < DEPTH - 1; k++) v_q[k] <= v_q[k+1];
      v_q[DEPTH-1] <= 1'b0;
      if (put) v_q[ins] <= 1'b1;
      out_v <= v_q[0];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH - 1; k++) begin
      op_q[k]  <= op_q[k+1];
      dst_q[k] <= dst_q[k+1];
      wr_q[k]  <= wr_q[k+1];
    end
    if (put) begin
      op_q[ins]  <= put_op;
      dst_q[ins] <= put_dst;
      wr_q[ins]  <= put_wr;
    end
    out_op  <= op_q[0];
    out_dst <= dst_q[0];
    out_wr  <= wr_q[0];
  end

endmodule

// File: rtl/fpsb_issue_ctl.sv
`timescale 1ns/1ps
module fpsb_issue_ctl
  import fpsb_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int MUL_RATE = 6,
  parameter int SLACK    = 2,
  localparam int AW      = $clog2(NREG),
  localparam int DEPTH   = MAX_LAT + SLACK + 1,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [3:0]    req_op,
  input  logic          req_dbl,
  input  logic [AW-1:0] req_dst,
  input  logic [AW-1:0] req_sa,
  input  logic [AW-1:0] req_sb,
  output logic          issue_ok,
  output logic          issue_stall,
  output logic          issue_trap,
  output logic          cpl_valid,
  output logic [3:0]    cpl_op,
  output logic [AW-1:0] cpl_dst,
  output logic          cpl_wr
);

  dec_t            dec;
  logic [NREG-1:0] reg_busy;
  logic            mul_busy;
  logic            arith_busy;
  logic            fit;
  logic [CW-1:0]   fit_at;
  logic            bad;
  logic            hazard;
  logic            unit_hold;
  logic            go;
  logic            hold;

  always_comb begin
    dec       = op_decode(req_op);
    bad       = req_dbl || !dec.legal;
    hazard    = (dec.rd_a && reg_busy[req_sa]) ||
                (dec.rd_b && reg_busy[req_sb]) ||
                (dec.wr_d && reg_busy[req_dst]);
    unit_hold = ((dec.unit == U_MUL)   && mul_busy) ||
                ((dec.unit == U_ARITH) && arith_busy);
    go        = req_valid && !bad && !hazard && !unit_hold && fit;
    hold      = req_valid && !bad && !go;
  end

  fpsb_countdown #(.CW(CW)) u_mul_gap (
    .clk  (clk),
    .rst  (rst),
    .load (go && (dec.unit == U_MUL)),
    .val  (CW'(MUL_RATE - 1)),
    .busy (mul_busy)
  );

  fpsb_countdown #(.CW(CW)) u_arith_occ (
    .clk  (clk),
    .rst  (rst),
    .load (go && (dec.unit == U_ARITH)),
    .val  (CW'(dec.lat) - CW'(1)),
    .busy (arith_busy)
  );

  fpsb_reg_pend #(.NREG(NREG), .AW(AW), .CW(CW)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .ld     (go && dec.wr_d),
    .ld_idx (req_dst),
    .ld_val (fit_at - CW'(1)),
    .busy   (reg_busy)
  );

  fpsb_timeline #(.DEPTH(DEPTH), .SLACK(SLACK), .AW(AW), .CW(CW)) u_tl (
    .clk      (clk),
    .rst      (rst),
    .want_lat (CW'(dec.lat)),
    .put      (go),
    .put_op   (req_op),
    .put_dst  (req_dst),
    .put_wr   (dec.wr_d),
    .fit      (fit),
    .fit_at   (fit_at),
    .out_v    (cpl_valid),
    .out_op   (cpl_op),
    .out_dst  (cpl_dst),
    .out_wr   (cpl_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_ok    <= 1'b0;
      issue_stall <= 1'b0;
      issue_trap  <= 1'b0;
    end else begin
      issue_ok    <= go;
      issue_stall <= hold;
      issue_trap  <= req_valid && bad;
    end
  end

endmodule

// File: rtl/fpsb_issue_chk.sv
`timescale 1ns/1ps
module fpsb_issue_chk
  import fpsb_pkg::*;
#(
  parameter int MUL_RATE = 6
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [3:0] req_op,
  input logic       req_dbl,
  input logic       issue_ok,
  input logic       issue_stall,
  input logic       issue_trap,
  input logic       cpl_valid,
  input logic [3:0] cpl_op
);

  logic       prev_val;
  logic [3:0] prev_op;
  logic [7:0] since_mul;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_val  <= 1'b0;
      prev_op   <= '0;
      since_mul <= 8'hFF;
    end else begin
      prev_val <= req_valid;
      prev_op  <= req_op;
      if (issue_ok && prev_val && (prev_op == OP_MUL)) since_mul <= 8'd1;
      else if (since_mul != 8'hFF) since_mul <= since_mul + 8'd1;
    end
  end

  assert_single_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({issue_ok, issue_stall, issue_trap}) <= 1);

  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(issue_ok || issue_stall || issue_trap));

  assert_wide_traps_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dbl) |=> issue_trap);

  assert_mul_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && prev_val && (prev_op == OP_MUL)) |-> (since_mul >= 8'(MUL_RATE)));

  assert_cpl_code_R10: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> (cpl_op <= OP_STORE));

endmodule

bind fpsb_issue_ctl fpsb_issue_chk #(.MUL_RATE(MUL_RATE)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_dbl     (req_dbl),
  .issue_ok    (issue_ok),
  .issue_stall (issue_stall),
  .issue_trap  (issue_trap),
  .cpl_valid   (cpl_valid),
  .cpl_op      (cpl_op)
);

// File: tb/test_fpsb_issue_ctl.sv
`timescale 1ns/1ps
module test_fpsb_issue_ctl;
  import fpsb_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic       req_dbl = 1'b0;
  logic [4:0] req_dst = '0;
  logic [4:0] req_sa = '0;
  logic [4:0] req_sb = '0;
  logic       issue_ok, issue_stall, issue_trap;
  logic       cpl_valid, cpl_wr;
  logic [3:0] cpl_op;
  logic [4:0] cpl_dst;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int e0     = 0;

  int         lg_n = 0;
  int         lg_cyc [16];
  logic [3:0] lg_op  [16];
  logic [4:0] lg_dst [16];
  logic       lg_wr  [16];

  fpsb_issue_ctl i_fpsb_issue_ctl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_dbl(req_dbl),
    .req_dst(req_dst), .req_sa(req_sa), .req_sb(req_sb),
    .issue_ok(issue_ok), .issue_stall(issue_stall), .issue_trap(issue_trap),
    .cpl_valid(cpl_valid), .cpl_op(cpl_op), .cpl_dst(cpl_dst), .cpl_wr(cpl_wr)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cpl_valid && lg_n < 16) begin
      lg_cyc[lg_n] = cyc;
      lg_op[lg_n]  = cpl_op;
      lg_dst[lg_n] = cpl_dst;
      lg_wr[lg_n]  = cpl_wr;
      lg_n = lg_n + 1;
    end
  end

  // {op[12:9], dbl[8], outcome[7:6] (0 accept, 2 trap), latency[5:0]}
  localparam logic [12:0] VEC [19] = '{
    {4'd0,  1'b0, 2'd0, 6'd4},  {4'd1,  1'b0, 2'd0, 6'd4},
    {4'd2,  1'b0, 2'd0, 6'd8},  {4'd3,  1'b0, 2'd0, 6'd32},
    {4'd4,  1'b0, 2'd0, 6'd31}, {4'd5,  1'b0, 2'd0, 6'd3},
    {4'd6,  1'b0, 2'd0, 6'd4},  {4'd7,  1'b0, 2'd0, 6'd6},
    {4'd8,  1'b0, 2'd0, 6'd1},  {4'd9,  1'b0, 2'd0, 6'd1},
    {4'd10, 1'b0, 2'd0, 6'd1},  {4'd11, 1'b0, 2'd0, 6'd2},
    {4'd12, 1'b0, 2'd0, 6'd1},  {4'd13, 1'b0, 2'd2, 6'd0},
    {4'd14, 1'b0, 2'd2, 6'd0},  {4'd15, 1'b0, 2'd2, 6'd0},
    {4'd0,  1'b1, 2'd2, 6'd0},  {4'd2,  1'b1, 2'd2, 6'd0},
    {4'd4,  1'b1, 2'd2, 6'd0}
  };

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [2:0] exp);
    chk(tag, int'({issue_ok, issue_stall, issue_trap}), int'(exp));
  endtask

  task automatic req(input logic [3:0] op, input logic dbl, input int d, input int a, input int b);
    req_valid = 1'b1;
    req_op    = op;
    req_dbl   = dbl;
    req_dst   = 5'(d);
    req_sa    = 5'(a);
    req_sb    = 5'(b);
    tick();
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    tick();
    tick();
    // R1: request during reset is ignored
    req(OP_ADD, 1'b0, 1, 2, 3);
    chk_out("R1 outcome during reset", 3'b000);
    chk("R1 cpl_valid during reset", int'(cpl_valid), 0);
    rst = 1'b0;
    tick();
    chk_out("R1 outcome after reset", 3'b000);
    chk("R1 cpl_valid after reset", int'(cpl_valid), 0);
    idle(3);
    chk_out("R9 idle outputs", 3'b000);

    // R2 / R7 / R10: table walk
    for (int i = 0; i < 19; i++) begin
      logic [3:0] op;
      logic       dbl;
      logic [1:0] res;
      int         lat;
      logic       wr;
      op  = VEC[i][12:9];
      dbl = VEC[i][8];
      res = VEC[i][7:6];
      lat = int'(VEC[i][5:0]);
      wr  = (op != OP_CMP) && (op != OP_STORE);
      lg_n = 0;
      e0 = cyc + 1;
      req(op, dbl, i + 1, 31, 31);
      if (res == 2'd0) begin
        chk_out("R2 accept", 3'b100);
        idle(40);
        chk("R2 completion count", lg_n, 1);
        chk("R2 latency", lg_cyc[0] - e0, lat);
        chk("R10 cpl_op", int'(lg_op[0]), int'(op));
        chk("R10 cpl_dst", int'(lg_dst[0]), i + 1);
        chk("R10 cpl_wr", int'(lg_wr[0]), int'(wr));
      end else begin
        chk_out("R7 trap outcome", 3'b001);
        idle(40);
        chk("R7 no completion", lg_n, 0);
      end
    end

    // R3: multiplier repeat rate
    lg_n = 0;
    e0 = cyc + 1;
    req(OP_MUL, 1'b0, 1, 30, 30);
    chk_out("R3 first mul", 3'b100);
    idle(4);
    req(OP_MUL, 1'b0, 2, 30, 30);
    chk_out("R3 mul at gap 5 stalls", 3'b010);
    req(OP_MUL, 1'b0, 2, 30, 30);
    chk_out("R3 mul at gap 6 accepted", 3'b100);
    idle(20);
    chk("R3 completions", lg_n, 2);
    chk("R3 second mul done", lg_cyc[1] - e0, 14);

    // R4: multiply and add overlap
    lg_n = 0;
    e0 = cyc + 1;
    req(OP_MUL, 1'b0, 3, 30, 30);
    chk_out("R4 mul", 3'b100);
    req(OP_ADD, 1'b0, 4, 30, 30);
    chk_out("R4 add next cycle", 3'b100);
    idle(12);
    chk("R4 add first", int'(lg_op[0]), int'(OP_ADD));
    chk("R4 add done", lg_cyc[0] - e0, 5);
    chk("R4 mul done", lg_cyc[1] - e0, 8);

    // R5: shared unit busy through divide
    lg_n = 0;
    e0 = cyc + 1;
    req(OP_DIV, 1'b0, 5, 30, 30);
    chk_out("R5 div", 3'b100);
    req(OP_ADD, 1'b0, 6, 30, 30);
    chk_out("R5 add behind div stalls", 3'b010);
    req(OP_LOAD, 1'b0, 9, 0, 0);
    chk_out("R5 load passes div", 3'b100);
    idle(28);
    req(OP_ADD, 1'b0, 6, 30, 30);
    chk_out("R5 add at E+31 stalls", 3'b010);
    req(OP_ADD, 1'b0, 6, 30, 30);
    chk_out("R5 add at E+32 accepted", 3'b100);
    idle(10);
    chk("R5 completions", lg_n, 3);
    chk("R5 div done", lg_cyc[1] - e0, 32);
    chk("R5 add done", lg_cyc[2] - e0, 36);

    // R6: register hazards
    lg_n = 0;
    req(OP_ADD, 1'b0, 10, 30, 30);
    chk_out("R6 producer", 3'b100);
    req(OP_MUL, 1'b0, 11, 10, 30);
    chk_out("R6 source A pending", 3'b010);
    req(OP_LOAD, 1'b0, 10, 0, 0);
    chk_out("R6 destination pending", 3'b010);
    req(OP_MUL, 1'b0, 11, 30, 10);
    chk_out("R6 source B pending", 3'b010);
    req(OP_MUL, 1'b0, 11, 10, 30);
    chk_out("R6 accepted at completion edge", 3'b100);
    idle(12);

    // R8: completion clash ordering
    lg_n = 0;
    e0 = cyc + 1;
    req(OP_MUL, 1'b0, 12, 30, 30);
    chk_out("R8 mul", 3'b100);
    idle(5);
    req(OP_LOAD, 1'b0, 13, 0, 0);
    chk_out("R8 load", 3'b100);
    req(OP_ABS, 1'b0, 14, 25, 0);
    chk_out("R8 abs", 3'b100);
    req(OP_MUL, 1'b0, 15, 14, 30);
    chk_out("R8 dependent stall 1", 3'b010);
    req(OP_MUL, 1'b0, 15, 14, 30);
    chk_out("R8 dependent stall 2", 3'b010);
    req(OP_MUL, 1'b0, 15, 14, 30);
    chk_out("R8 dependent accepted", 3'b100);
    idle(20);
    chk("R8 completions", lg_n, 4);
    chk("R8 mul done", lg_cyc[0] - e0, 8);
    chk("R8 load delayed", lg_cyc[1] - e0, 9);
    chk("R8 load dst", int'(lg_dst[1]), 13);
    chk("R8 abs delayed twice", lg_cyc[2] - e0, 10);
    chk("R8 abs dst", int'(lg_dst[2]), 14);
    chk("R8 dependent done", lg_cyc[3] - e0, 18);

    // R7: traps leave state untouched and beat stalls
    lg_n = 0;
    e0 = cyc + 1;
    req(OP_DIV, 1'b1, 16, 30, 30);
    chk_out("R7 wide divide", 3'b001);
    req(OP_ADD, 1'b0, 16, 30, 30);
    chk_out("R7 unit and register untouched", 3'b100);
    req(OP_MUL, 1'b0, 17, 30, 30);
    chk_out("R7 mul", 3'b100);
    req(OP_MUL, 1'b1, 18, 30, 30);
    chk_out("R7 trap beats mul gap", 3'b001);
    req(4'd13, 1'b0, 19, 30, 30);
    chk_out("R7 reserved code", 3'b001);
    idle(20);
    chk("R7 only legal completions", lg_n, 2);
    chk("R7 add done", lg_cyc[0] - e0, 5);
    chk_out("R9 quiet after idle", 3'b000);

    finish_run();
  end

endmodule